// File: doc/BRIEF.md
# Interrupt CPU Interface

This block is the per-processor front end of an interrupt controller. A distributor presents one candidate at a time: a valid flag, a 10-bit interrupt number, the 2-bit number of the processor that raised it, and an 8-bit priority where a lower number is more urgent. The block decides whether the candidate may interrupt the processor. If so, it pulls an active-low request line.

Software reaches the block through a small word-addressed register port. It can enable signalling, set a priority threshold and choose how many low priority bits are ignored when deciding preemption. Reading the acknowledge register takes the candidate into service. Writing the end-of-service register retires it. The block keeps a stack of the priorities now in service, so a more urgent interrupt can nest inside a less urgent one. On acknowledge it pulses clear-pending and set-active back to the distributor, and on end of service it pulses clear-active.

A four-state machine tracks where the interface stands: `CIF_QUIET` (nothing in service, nothing to signal), `CIF_SIGNAL` (nothing in service, request raised), `CIF_BUSY` (in service, no preemptor) and `CIF_PREEMPT` (in service, a preemptor signalled). At each clock edge the state moves to the entry picked by two inputs: whether the stack is non-empty and whether the current candidate qualifies. The named transitions are `raise`, `drop`, `take`, `retire`, `nest` and `settle`. The request line is low only in `CIF_SIGNAL` and `CIF_PREEMPT`.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset `irq_n` is 1, `stack_uflow` is 0, the control, threshold and binary-point registers read 0, running priority reads 0xFF, and highest-pending reads 1023 when no candidate is valid.
- R2: Control bit 0 gates signalling. While it is 0, `irq_n` stays 1 and an acknowledge read returns 1023.
- R3: A candidate qualifies only if `cand_valid` is 1 and its priority is numerically below the 8-bit threshold register (offset 0x04). A threshold of 0 blocks everything.
- R4: Binary point (offset 0x08, 3 bits) value b gives a group mask with bits 7 down to b+1 set (b=0 gives 0xFE, b=7 gives 0x00). While something is in service, a candidate qualifies only if (priority AND mask) is strictly less than (running priority AND mask).
- R5: An acknowledge read (offset 0x0C) of a qualifying candidate returns the ID in bits 9:0 and the source in bits 11:10. It pushes the candidate's priority, so running priority (offset 0x14) reads it afterwards. In the cycle after the read, `clr_pend_o` and `set_act_o` pulse high for one cycle with `ack_id_o` equal to the ID.
- R6: An acknowledge read with no qualifying candidate returns 1023 with the source field 0. It raises no strobe and leaves running priority unchanged.
- R7: A write to offset 0x10 pulses `clr_act_o` for one cycle in the next cycle, with `eoi_id_o` equal to write-data bits 9:0, and pops the stack. Running priority returns to the previous entry, or to 0xFF when the stack is empty.
- R8: Highest-pending (offset 0x18) reads the candidate ID in bits 9:0 when `cand_valid` is 1, else 1023, whatever the enable.
- R9: The stack holds `STACK_DEPTH` (default 8) entries. An acknowledge beyond that depth still returns the ID, but its priority is not stored.
- R10: An end-of-service write while the stack is empty sets `stack_uflow`, which stays 1 until reset.
- R11: Register reads return the stored bits zero-extended (control 1 bit, threshold 8 bits, binary point 3 bits). Writes to the running-priority, highest-pending or acknowledge offsets, or to offsets 0x1C and above, change nothing. Those offsets read as 0.
- R12: `irq_n` is registered. It changes in the clock edge after the qualifying condition changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor candidate present |
| cand_id | input | 10 | Candidate interrupt number |
| cand_src | input | 2 | Candidate source processor number |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| irq_n | output | 1 | Active-low interrupt request |
| clr_pend_o | output | 1 | Clear-pending strobe to distributor |
| set_act_o | output | 1 | Set-active strobe to distributor |
| ack_id_o | output | 10 | ID for the acknowledge strobes |
| clr_act_o | output | 1 | Clear-active strobe to distributor |
| eoi_id_o | output | 10 | ID for the clear-active strobe |
| stack_uflow | output | 1 | Sticky stack underflow flag |

## Verification
A wrong stack pointer or a stale stack entry shows up on the running-priority read at once. It also shows one cycle later on `irq_n`, because the preemption compare uses the top entry. A state machine stuck in the wrong state shows on `irq_n` after one edge, since the request is decoded straight from the state. Bad group masking shows only with nested service, where two priorities share a group. The bench therefore sets up such pairs on purpose and drives the stack past its depth and below empty.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;

    localparam int ID_W   = 10;
    localparam int SRC_W  = 2;
    localparam int PRIO_W = 8;
    localparam int BP_W   = 3;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0]   NO_IRQ_ID = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_PMR  = 'h04;
    localparam int OFS_BP   = 'h08;
    localparam int OFS_ACK  = 'h0C;
    localparam int OFS_EOI  = 'h10;
    localparam int OFS_RUN  = 'h14;
    localparam int OFS_HPND = 'h18;

    typedef enum logic [1:0] {
        CIF_QUIET   = 2'd0,
        CIF_SIGNAL  = 2'd1,
        CIF_BUSY    = 2'd2,
        CIF_PREEMPT = 2'd3
    } cif_state_e;

    // Group mask: keep the priority bits above the binary point.
    function automatic logic [PRIO_W-1:0] group_mask(input logic [BP_W-1:0] bp);
        logic [PRIO_W-1:0] m;
        for (int i = 0; i < PRIO_W; i++) begin
            m[i] = (i > int'(bp));
        end
        return m;
    endfunction

endpackage

// File: rtl/cif_regs.sv
module cif_regs
    import irq_cif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PRIO_W-1:0] wdata,
    output logic              en_q,
    output logic [PRIO_W-1:0] pmr_q,
    output logic [BP_W-1:0]   bp_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            pmr_q <= '0;
            bp_q  <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(OFS_CTRL)) en_q  <= wdata[0];
            if (addr == ADDR_W'(OFS_PMR))  pmr_q <= wdata;
            if (addr == ADDR_W'(OFS_BP))   bp_q  <= wdata[BP_W-1:0];
        end
    end

endmodule

// File: rtl/cif_prio_stack.sv
module cif_prio_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     push_val,
    output logic [W-1:0]     top_val,
    output logic [CNT_W-1:0] depth,
    output logic             uflow
);

    logic [W-1:0] mem [DEPTH];

    // One storage slot per level; a slot loads when the pointer sits on it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '1;
            end else if (push && depth == CNT_W'(g)) begin
                mem[g] <= push_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
            uflow <= 1'b0;
        end else if (push) begin
            if (depth < CNT_W'(DEPTH)) depth <= depth + 1'b1;
        end else if (pop) begin
            if (depth == '0) uflow <= 1'b1;
            else             depth <= depth - 1'b1;
        end
    end

    always_comb begin
        top_val = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth == CNT_W'(i + 1)) top_val = mem[i];
        end
    end

endmodule

// File: rtl/cif_fsm.sv
module cif_fsm
    import irq_cif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want,
    input  logic       in_service,
    output cif_state_e state,
    output logic       irq_n
);

    cif_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            CIF_QUIET:   nxt = in_service ? (want ? CIF_PREEMPT : CIF_BUSY)      // take
                                          : (want ? CIF_SIGNAL  : CIF_QUIET);    // raise
            CIF_SIGNAL:  nxt = in_service ? (want ? CIF_PREEMPT : CIF_BUSY)      // take
                                          : (want ? CIF_SIGNAL  : CIF_QUIET);    // drop
            CIF_BUSY:    nxt = in_service ? (want ? CIF_PREEMPT : CIF_BUSY)      // nest
                                          : (want ? CIF_SIGNAL  : CIF_QUIET);    // retire
            CIF_PREEMPT: nxt = in_service ? (want ? CIF_PREEMPT : CIF_BUSY)      // settle
                                          : (want ? CIF_SIGNAL  : CIF_QUIET);    // retire
            default:     nxt = CIF_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CIF_QUIET;
        else        state <= nxt;
    end

    always_comb begin
        irq_n = !(state == CIF_SIGNAL || state == CIF_PREEMPT);
    end

endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
    import irq_cif_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n,
    output logic              clr_pend_o,
    output logic              set_act_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic              clr_act_o,
    output logic [ID_W-1:0]   eoi_id_o,
    output logic              stack_uflow
);

    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    logic              en_q;
    logic [PRIO_W-1:0] pmr_q;
    logic [BP_W-1:0]   bp_q;
    logic [PRIO_W-1:0] run_prio;
    logic [CNT_W-1:0]  stk_depth;
    logic [PRIO_W-1:0] gmask;
    logic              in_service, want, ack_hit, ack_take, eoi_hit;
    cif_state_e        state;
    logic              ack_pulse_q, eoi_pulse_q;

    cif_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata[PRIO_W-1:0]),
        .en_q  (en_q),
        .pmr_q (pmr_q),
        .bp_q  (bp_q)
    );

    assign gmask      = group_mask(bp_q);
    assign in_service = (stk_depth != '0);
    assign want       = cand_valid && en_q && (cand_prio < pmr_q) &&
                        (!in_service || ((cand_prio & gmask) < (run_prio & gmask)));
    assign ack_hit    = reg_rd && (reg_addr == ADDR_W'(OFS_ACK));
    assign ack_take   = ack_hit && want;
    assign eoi_hit    = reg_wr && (reg_addr == ADDR_W'(OFS_EOI));

    cif_prio_stack #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_take),
        .pop      (eoi_hit),
        .push_val (cand_prio),
        .top_val  (run_prio),
        .depth    (stk_depth),
        .uflow    (stack_uflow)
    );

    cif_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (want),
        .in_service (in_service),
        .state      (state),
        .irq_n      (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_pulse_q <= 1'b0;
            ack_id_o    <= '0;
            eoi_pulse_q <= 1'b0;
            eoi_id_o    <= '0;
        end else begin
            ack_pulse_q <= ack_take;
            eoi_pulse_q <= eoi_hit;
            if (ack_take) ack_id_o <= cand_id;
            if (eoi_hit)  eoi_id_o <= reg_wdata[ID_W-1:0];
        end
    end

    assign clr_pend_o = ack_pulse_q;
    assign set_act_o  = ack_pulse_q;
    assign clr_act_o  = eoi_pulse_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (int'(reg_addr))
                OFS_CTRL: reg_rdata = DATA_W'(en_q);
                OFS_PMR:  reg_rdata = DATA_W'(pmr_q);
                OFS_BP:   reg_rdata = DATA_W'(bp_q);
                OFS_ACK:  reg_rdata = want ? DATA_W'({cand_src, cand_id})
                                           : DATA_W'(NO_IRQ_ID);
                OFS_RUN:  reg_rdata = DATA_W'(run_prio);
                OFS_HPND: reg_rdata = cand_valid ? DATA_W'(cand_id) : DATA_W'(NO_IRQ_ID);
                default:  reg_rdata = '0;
            endcase
        end
    end

    logic unused_state;
    assign unused_state = ^state;

endmodule

// File: rtl/irq_cif_checker.sv
module irq_cif_checker
    import irq_cif_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STACK_DEPTH = 8,
    localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              en_q,
    input logic [PRIO_W-1:0] pmr_q,
    input logic              cand_valid,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              clr_pend_o,
    input logic              clr_act_o,
    input logic [CNT_W-1:0]  stk_depth,
    input logic              stack_uflow
);

    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(en_q));

    assert_irq_below_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(cand_valid && (cand_prio < pmr_q)));

    assert_ack_strobe_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend_o |-> $past(reg_rd && reg_addr == ADDR_W'(OFS_ACK)));

    assert_eoi_strobe_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act_o |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_EOI)));

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= CNT_W'(STACK_DEPTH));

    assert_uflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stack_uflow) |-> stack_uflow);

endmodule

bind irq_cpu_if irq_cif_checker #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_n       (irq_n),
    .en_q        (en_q),
    .pmr_q       (pmr_q),
    .cand_valid  (cand_valid),
    .cand_prio   (cand_prio),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .clr_pend_o  (clr_pend_o),
    .clr_act_o   (clr_act_o),
    .stk_depth   (stk_depth),
    .stack_uflow (stack_uflow)
);

// File: tb/tb_irq_cpu_if.sv
module tb_irq_cpu_if;
    import irq_cif_pkg::*;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cand_valid = 1'b0;
    logic [ID_W-1:0]   cand_id = '0;
    logic [SRC_W-1:0]  cand_src = '0;
    logic [PRIO_W-1:0] cand_prio = '1;
    logic              reg_rd = 1'b0, reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_n, clr_pend_o, set_act_o, clr_act_o, stack_uflow;
    logic [ID_W-1:0]   ack_id_o, eoi_id_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_cpu_if #(.ADDR_W(ADDR_W), .STACK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_src(cand_src), .cand_prio(cand_prio), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .clr_pend_o(clr_pend_o), .set_act_o(set_act_o),
        .ack_id_o(ack_id_o), .clr_act_o(clr_act_o), .eoi_id_o(eoi_id_o),
        .stack_uflow(stack_uflow)
    );

    // {valid, threshold, priority, expect request}
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 8'hFF, 8'hFE, 1'b1},
        {1'b1, 8'hFF, 8'hFF, 1'b0},
        {1'b1, 8'h80, 8'h7F, 1'b1},
        {1'b1, 8'h80, 8'h80, 1'b0},
        {1'b1, 8'h80, 8'h81, 1'b0},
        {1'b1, 8'h01, 8'h00, 1'b1},
        {1'b1, 8'h00, 8'h00, 1'b0},
        {1'b1, 8'h10, 8'h0F, 1'b1},
        {1'b0, 8'hFF, 8'h10, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cand(input logic v, input int id, input int src, input logic [7:0] p);
        cand_valid = v; cand_id = ID_W'(id); cand_src = SRC_W'(src); cand_prio = p;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", 32'(irq_n), 32'd1);
        chk("R1 uflow", 32'(stack_uflow), 32'd0);
        rd(OFS_CTRL, d); chk("R1 ctrl", d, 32'd0);
        rd(OFS_PMR, d);  chk("R1 pmr", d, 32'd0);
        rd(OFS_BP, d);   chk("R1 bp", d, 32'd0);
        rd(OFS_RUN, d);  chk("R1 running", d, 32'hFF);
        rd(OFS_HPND, d); chk("R1 hppend", d, 32'd1023);

        // R2 disabled: no request, ack gives 1023
        wr(OFS_PMR, 32'hFF);
        cand(1'b1, 9, 1, 8'h10);
        repeat (2) @(negedge clk);
        chk("R2 irq_n disabled", 32'(irq_n), 32'd1);
        rd(OFS_ACK, d); chk("R2 ack disabled", d, 32'd1023);

        // R8 highest pending independent of enable
        rd(OFS_HPND, d); chk("R8 hppend id", d, 32'd9);

        // R12 registered request timing
        wr(OFS_CTRL, 32'h1);
        #1 chk("R12 not yet", 32'(irq_n), 32'd1);
        @(negedge clk);
        chk("R12 asserted", 32'(irq_n), 32'd0);

        // R3 threshold table
        for (int i = 0; i < NV; i++) begin
            wr(OFS_PMR, 32'(VEC[i][16:9]));
            cand(VEC[i][17], 40 + i, 0, VEC[i][8:1]);
            repeat (2) @(negedge clk);
            chk($sformatf("R3 vec%0d irq_n", i), 32'(irq_n), 32'(!VEC[i][0]));
        end

        // R11 register widths and ignored writes
        wr(OFS_CTRL, 32'hFFFF_FFFF); rd(OFS_CTRL, d); chk("R11 ctrl width", d, 32'd1);
        wr(OFS_BP, 32'hFF);          rd(OFS_BP, d);   chk("R11 bp width", d, 32'd7);
        wr(OFS_RUN, 32'h12);         rd(OFS_RUN, d);  chk("R11 running ro", d, 32'hFF);
        wr('h20, 32'h55);            rd('h20, d);     chk("R11 reserved", d, 32'd0);
        rd(OFS_EOI, d);                               chk("R11 eoi reads 0", d, 32'd0);
        rd(OFS_CTRL, d);                              chk("R11 ctrl kept", d, 32'd1);
        wr(OFS_PMR, 32'hFF);

        // R5 acknowledge, R6 no candidate, R7 end of service, R4 group masking
        wr(OFS_BP, 32'd2);
        cand(1'b1, 100, 3, 8'h44);
        @(negedge clk);
        rd(OFS_ACK, d); chk("R5 ack data", d, {20'd0, 2'd3, 10'd100});
        chk("R5 clr_pend", 32'(clr_pend_o), 32'd1);
        chk("R5 set_act", 32'(set_act_o), 32'd1);
        chk("R5 ack_id", 32'(ack_id_o), 32'd100);
        rd(OFS_RUN, d); chk("R5 running", d, 32'h44);
        cand(1'b1, 101, 0, 8'h41);
        repeat (2) @(negedge clk);
        chk("R4 same group no irq", 32'(irq_n), 32'd1);
        rd(OFS_ACK, d); chk("R6 ack spurious", d, 32'd1023);
        chk("R6 no strobe", 32'(clr_pend_o), 32'd0);
        rd(OFS_RUN, d); chk("R6 running kept", d, 32'h44);
        wr(OFS_BP, 32'd0);
        repeat (2) @(negedge clk);
        chk("R4 finer point preempts", 32'(irq_n), 32'd0);
        wr(OFS_BP, 32'd2);
        cand(1'b1, 102, 1, 8'h3F);
        repeat (2) @(negedge clk);
        chk("R4 better group irq", 32'(irq_n), 32'd0);
        rd(OFS_ACK, d); chk("R4 nested ack", d, {20'd0, 2'd1, 10'd102});
        rd(OFS_RUN, d); chk("R4 running nested", d, 32'h3F);
        cand(1'b0, 0, 0, 8'hFF);
        wr(OFS_EOI, 32'hFFFF_FC00 | 32'd102);
        chk("R7 clr_act", 32'(clr_act_o), 32'd1);
        chk("R7 eoi_id", 32'(eoi_id_o), 32'd102);
        rd(OFS_RUN, d); chk("R7 running popped", d, 32'h44);
        chk("R7 pulse single", 32'(clr_act_o), 32'd0);
        wr(OFS_EOI, 32'd100);
        rd(OFS_RUN, d); chk("R7 running idle", d, 32'hFF);

        // R9 depth limit, R10 underflow
        wr(OFS_BP, 32'd0);
        for (int k = 0; k <= DEPTH; k++) begin
            cand(1'b1, 32 + k, k % 4, 8'(8'h80 - 8'h10 * k));
            @(negedge clk);
            rd(OFS_ACK, d);
            chk($sformatf("R9 nest ack %0d", k), d, {20'd0, 2'(k % 4), 10'(32 + k)});
        end
        cand(1'b0, 0, 0, 8'hFF);
        rd(OFS_RUN, d); chk("R9 overflow ignored", d, 32'h10);
        for (int j = 0; j < DEPTH; j++) wr(OFS_EOI, 32'(40 - j));
        rd(OFS_RUN, d); chk("R9 all popped", d, 32'hFF);
        chk("R10 no uflow yet", 32'(stack_uflow), 32'd0);
        wr(OFS_EOI, 32'd32);
        chk("R10 uflow set", 32'(stack_uflow), 32'd1);
        repeat (3) @(negedge clk);
        chk("R10 uflow sticky", 32'(stack_uflow), 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule